// File: doc/BRIEF.md
# Rotating-frame to hexagonal g-h frame transform

This block takes a voltage reference expressed in a rotating two-axis frame and turns it into coordinates in the 60-degree g-h frame used by a multilevel space vector modulator. Each sample is made of two signed components, `d` and `q`, and an 8-bit rotation angle. The block first rotates the vector by the angle. It then applies the non-orthogonal scaling g = sqrt3*x - y and h = 2*y.

Sine and cosine values come from one on-chip sine table. The table is filled when the design is elaborated, and the cosine is read from the same table a quarter turn ahead. Each output is an 11-bit fixed-point number with a 3-bit signed integer part and an 8-bit fraction. A later stage splits it into a lattice point and a dwell fraction. Results that do not fit in the output range are clamped to the nearest end of the range.

The block is a straight pipeline with a valid strobe. It accepts one sample on every clock and returns each result a fixed number of cycles later.

Top module: `dq_gh_xform`

## Requirements
- R1: While reset is asserted and after it is released, with no sample accepted yet, `out_valid` is 0 and `g_out` and `h_out` are both 0.
- R2: Sine entry k of the 256-entry table is round(127*sin(2*pi*k/256)), with ties rounded away from zero, and is read as a fraction of 128. The cosine for angle a is the sine entry at address (a+64) mod 256. Example: with a = 64, d = 32 and q = 0, the outputs are exactly g = -254 and h = 508.
- R3: `d_in` and `q_in` are 8-bit two's complement values with 5 fractional bits, so they cover -4.0 to +3.969. `theta_in` is unsigned, and 256 counts make one full turn.
- R4: With s and c the table values for the angle, x = d*c - q*s and y = d*s + q*c. The outputs are g = sqrt3*x - y and h = 2*y. Each output is within 2 output LSBs of this expression evaluated in real arithmetic.
- R5: `g_out` and `h_out` are two's complement, with 8 fractional bits and one LSB equal to 1/256. The final result is rounded to the nearest LSB.
- R6: A result above 1023 LSB is output as exactly 1023, and a result below -1024 LSB is output as exactly -1024. A result never wraps around.
- R7: A sample that is accepted on a rising edge with `in_valid` = 1 produces `out_valid` = 1 and its results on the fourth rising edge, counting the accepting edge as the first. `out_valid` follows `in_valid` delayed by 4 cycles, samples may arrive on back-to-back cycles, and results leave in arrival order.
- R8: After `out_valid` falls, `g_out` and `h_out` keep the last result until the next result is delivered.
- R9: An accepted sample with d = 0 and q = 0 gives g = 0 and h = 0 exactly. A sample with angle 0 and q = 0 gives h = 0 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A sample is present on the inputs this cycle |
| d_in | input | 8 | First rotating-frame component, signed, 5 fractional bits |
| q_in | input | 8 | Second rotating-frame component, signed, 5 fractional bits |
| theta_in | input | 8 | Rotation angle, 256 counts per turn |
| out_valid | output | 1 | `g_out` and `h_out` carry a new result |
| g_out | output | 11 | g coordinate, signed, 8 fractional bits |
| h_out | output | 11 | h coordinate, signed, 8 fractional bits |

## Verification
A sample accepted on a rising edge has its `out_valid` and both coordinates visible after the third rising edge that follows. The bench drives inputs on falling edges and records the `in_valid` value seen at each rising edge. On each falling edge it compares `out_valid` against the value recorded three edges earlier, and it pairs every valid output with the oldest expected result still pending. Saturated, zero and quarter-turn cases are compared exactly. The angle sweeps are compared within 2 LSB of a real-valued model. The hold behaviour is checked on the idle cycles after a burst.

// File: rtl/gh_xform_pkg.sv
package gh_xform_pkg;

  // Fixed-point sqrt(3) with frac_bits fractional bits, rounded to nearest
  function automatic int sqrt3_fixed(input int frac_bits);
    real v;
    v = 1.7320508075688772;
    for (int i = 0; i < frac_bits; i++) v = v * 2.0;
    return $rtoi(v + 0.5);
  endfunction

  // One sine sample scaled to amp, ties rounded away from zero (R2)
  function automatic int sine_at(input int idx, input int depth, input int amp);
    real a;
    a = 6.283185307179586 * real'(idx) / real'(depth);
    a = $sin(a) * real'(amp);
    return (a >= 0.0) ? $rtoi(a + 0.5) : $rtoi(a - 0.5);
  endfunction

endpackage

// File: rtl/gh_sine_rom.sv
module gh_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [AW-1:0]        angle,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int DEPTH = 1 << AW;
  localparam int QTR   = DEPTH / 4;
  localparam int AMP   = (1 << (DW - 1)) - 1;

  logic signed [DW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    assign tbl[i] = DW'(gh_xform_pkg::sine_at(i, DEPTH, AMP));
  end

  logic [AW-1:0]        cos_addr;
  logic signed [DW-1:0] sin_n, cos_n;

  always_comb begin
    cos_addr = angle + AW'(QTR);
    sin_n    = sin_o;
    cos_n    = cos_o;
    if (en) begin
      sin_n = tbl[angle];
      cos_n = tbl[cos_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= sin_n;
      cos_o <= cos_n;
    end
  end
endmodule

// File: rtl/gh_rotator.sv
module gh_rotator #(
  parameter int IW = 8,
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [IW-1:0] d_i,
  input  logic signed [IW-1:0] q_i,
  input  logic signed [SW-1:0] sin_i,
  input  logic signed [SW-1:0] cos_i,
  output logic                 v_o,
  output logic signed [IW+SW:0] x_o,
  output logic signed [IW+SW:0] y_o
);
  localparam int PW = IW + SW;
  localparam int RW = PW + 1;

  logic                 v_p;
  logic signed [PW-1:0] p_dc, p_qs, p_ds, p_qc;
  logic signed [PW-1:0] p_dc_n, p_qs_n, p_ds_n, p_qc_n;
  logic signed [RW-1:0] x_n, y_n;

  // Stage 2: four partial products
  always_comb begin
    p_dc_n = p_dc;
    p_qs_n = p_qs;
    p_ds_n = p_ds;
    p_qc_n = p_qc;
    if (v_i) begin
      p_dc_n = d_i * cos_i;
      p_qs_n = q_i * sin_i;
      p_ds_n = d_i * sin_i;
      p_qc_n = q_i * cos_i;
    end
  end

  // Stage 3: rotated components
  always_comb begin
    x_n = x_o;
    y_n = y_o;
    if (v_p) begin
      x_n = RW'(p_dc) - RW'(p_qs);
      y_n = RW'(p_ds) + RW'(p_qc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_p  <= 1'b0;
      p_dc <= '0;
      p_qs <= '0;
      p_ds <= '0;
      p_qc <= '0;
      v_o  <= 1'b0;
      x_o  <= '0;
      y_o  <= '0;
    end else begin
      v_p  <= v_i;
      p_dc <= p_dc_n;
      p_qs <= p_qs_n;
      p_ds <= p_ds_n;
      p_qc <= p_qc_n;
      v_o  <= v_p;
      x_o  <= x_n;
      y_o  <= y_n;
    end
  end
endmodule

// File: rtl/gh_scaler.sv
module gh_scaler #(
  parameter int XW = 17,
  parameter int XF = 12,
  parameter int KF = 12,
  parameter int OW = 11,
  parameter int OF = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  output logic                 v_o,
  output logic signed [OW-1:0] g_o,
  output logic signed [OW-1:0] h_o
);
  localparam int KW  = KF + 2;
  localparam int AW  = XW + KW + 1;
  localparam int GSH = XF + KF - OF;
  localparam int HSH = XF - OF;
  localparam logic signed [KW-1:0] KSQ3 = KW'(gh_xform_pkg::sqrt3_fixed(KF));
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (OW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  // Round to nearest (half up), then clamp to the output range (R5, R6)
  function automatic logic signed [OW-1:0] rnd_sat(input logic signed [AW-1:0] v,
                                                   input int sh);
    logic signed [AW-1:0] half, r;
    half = AW'(1) <<< (sh - 1);
    r    = (v + half) >>> sh;
    if (r > MAXV)      return MAXV[OW-1:0];
    else if (r < MINV) return MINV[OW-1:0];
    else               return r[OW-1:0];
  endfunction

  logic signed [AW-1:0] g_acc, h_acc;
  logic signed [OW-1:0] g_n, h_n;

  always_comb begin
    g_acc = (AW'(x_i) * AW'(KSQ3)) - (AW'(y_i) <<< KF);
    h_acc = AW'(y_i) <<< 1;
    g_n   = g_o;
    h_n   = h_o;
    if (v_i) begin
      g_n = rnd_sat(g_acc, GSH);
      h_n = rnd_sat(h_acc, HSH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      g_o <= '0;
      h_o <= '0;
    end else begin
      v_o <= v_i;
      g_o <= g_n;
      h_o <= h_n;
    end
  end
endmodule

// File: rtl/dq_gh_xform.sv
module dq_gh_xform #(
  parameter int IN_W     = 8,
  parameter int IN_FRAC  = 5,
  parameter int ANG_W    = 8,
  parameter int SIN_W    = 8,
  parameter int K_FRAC   = 12,
  parameter int OUT_W    = 11,
  parameter int OUT_FRAC = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  d_in,
  input  logic signed [IN_W-1:0]  q_in,
  input  logic [ANG_W-1:0]        theta_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] g_out,
  output logic signed [OUT_W-1:0] h_out
);
  localparam int ROT_W  = IN_W + SIN_W + 1;
  localparam int ROT_F  = IN_FRAC + SIN_W - 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  // Stage 1: capture the components next to the table read
  logic                   v_s1;
  logic signed [IN_W-1:0] d_s1, q_s1, d_n, q_n;

  always_comb begin
    d_n = d_s1;
    q_n = q_s1;
    if (in_valid) begin
      d_n = d_in;
      q_n = q_in;
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      v_s1 <= 1'b0;
      d_s1 <= '0;
      q_s1 <= '0;
    end else begin
      v_s1 <= in_valid;
      d_s1 <= d_n;
      q_s1 <= q_n;
    end
  end

  logic signed [SIN_W-1:0] sin_s1, cos_s1;

  gh_sine_rom #(.AW(ANG_W), .DW(SIN_W)) rom_i (
    .clk   (clk),
    .rst_n (rst_s2),
    .en    (in_valid),
    .angle (theta_in),
    .sin_o (sin_s1),
    .cos_o (cos_s1)
  );

  logic                    v_s3;
  logic signed [ROT_W-1:0] x_s3, y_s3;

  gh_rotator #(.IW(IN_W), .SW(SIN_W)) rot_i (
    .clk   (clk),
    .rst_n (rst_s2),
    .v_i   (v_s1),
    .d_i   (d_s1),
    .q_i   (q_s1),
    .sin_i (sin_s1),
    .cos_i (cos_s1),
    .v_o   (v_s3),
    .x_o   (x_s3),
    .y_o   (y_s3)
  );

  gh_scaler #(.XW(ROT_W), .XF(ROT_F), .KF(K_FRAC), .OW(OUT_W), .OF(OUT_FRAC)) scl_i (
    .clk   (clk),
    .rst_n (rst_s2),
    .v_i   (v_s3),
    .x_i   (x_s3),
    .y_i   (y_s3),
    .v_o   (out_valid),
    .g_o   (g_out),
    .h_o   (h_out)
  );
endmodule

// File: rtl/dq_gh_xform_chk.sv
module dq_gh_xform_chk #(
  parameter int IN_W  = 8,
  parameter int ANG_W = 8,
  parameter int OUT_W = 11
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  d_in,
  input logic signed [IN_W-1:0]  q_in,
  input logic [ANG_W-1:0]        theta_in,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] g_out,
  input logic signed [OUT_W-1:0] h_out
);
  // R7: out_valid is in_valid four cycles later
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 4));

  // R8: results hold once out_valid drops
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ($stable(g_out) && $stable(h_out)));

  // R9: a zero vector maps to the origin
  a_r9_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(d_in, 4) == '0 && $past(q_in, 4) == '0)
      |-> (g_out == '0 && h_out == '0));

  // R9: with angle 0 and q = 0, h is exactly zero
  a_r9_h_zero_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(theta_in, 4) == '0 && $past(q_in, 4) == '0)
      |-> (h_out == '0));
endmodule

bind dq_gh_xform dq_gh_xform_chk #(.IN_W(IN_W), .ANG_W(ANG_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .d_in(d_in), .q_in(q_in),
  .theta_in(theta_in), .out_valid(out_valid), .g_out(g_out), .h_out(h_out)
);

// File: tb/dq_gh_xform_tb_top.sv
`timescale 1ns/1ps
module dq_gh_xform_tb_top;
  localparam int QMAX  = 4096;
  localparam int LIMIT = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [7:0] d_in = '0;
  logic signed [7:0] q_in = '0;
  logic [7:0]        theta_in = '0;
  logic              out_valid;
  logic signed [10:0] g_out, h_out;

  always #2 clk = ~clk;

  dq_gh_xform dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .d_in(d_in), .q_in(q_in),
    .theta_in(theta_in), .out_valid(out_valid), .g_out(g_out), .h_out(h_out)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    mon_on  = 1'b0;
  bit    done    = 1'b0;
  bit    hist [8];
  int    exp_g [QMAX];
  int    exp_h [QMAX];
  int    exp_tol [QMAX];
  string exp_tag [QMAX];
  int    wr_idx = 0;
  int    rd_idx = 0;

  // Table sample per R2
  function automatic int sq(input int k);
    real a;
    a = 127.0 * $sin(6.283185307179586 * real'(k) / 256.0);
    return (a >= 0.0) ? $rtoi(a + 0.5) : $rtoi(a - 0.5);
  endfunction

  // Real-valued model of R4, R5, R6
  function automatic int mdl(input int d, input int q, input int th, input bit sel_h);
    int  s, c, r;
    real x, y, v;
    s = sq(th % 256);
    c = sq((th + 64) % 256);
    x = real'(d * c - q * s) / 4096.0;
    y = real'(d * s + q * c) / 4096.0;
    v = sel_h ? 2.0 * y : $sqrt(3.0) * x - y;
    v = v * 256.0;
    r = (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    if (r > 1023) r = 1023;
    if (r < -1024) r = -1024;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Record in_valid as sampled on each rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    hist[cyc & 7] = in_valid;
  end

  // Output monitor: latency (R7) and values in order
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid || hist[(cyc - 3) & 7])
        chk(out_valid == hist[(cyc - 3) & 7], "R7 out_valid timing",
            int'(out_valid), int'(hist[(cyc - 3) & 7]));
      if (out_valid) begin
        if (rd_idx >= wr_idx) begin
          chk(1'b0, "R7 unexpected result", int'(g_out), 0);
        end else begin
          int dg, dh;
          dg = int'(g_out) - exp_g[rd_idx];
          dh = int'(h_out) - exp_h[rd_idx];
          chk((dg <= exp_tol[rd_idx]) && (-dg <= exp_tol[rd_idx]),
              {exp_tag[rd_idx], " g"}, int'(g_out), exp_g[rd_idx]);
          chk((dh <= exp_tol[rd_idx]) && (-dh <= exp_tol[rd_idx]),
              {exp_tag[rd_idx], " h"}, int'(h_out), exp_h[rd_idx]);
          rd_idx++;
        end
      end
    end
  end

  task automatic push(input int d, input int q, input int th, input int tol, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    d_in     = 8'(d);
    q_in     = 8'(q);
    theta_in = 8'(th);
    exp_g[wr_idx]   = mdl(d, q, th, 1'b0);
    exp_h[wr_idx]   = mdl(d, q, th, 1'b1);
    exp_tol[wr_idx] = tol;
    exp_tag[wr_idx] = tag;
    wr_idx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      d_in     = 8'(i * 37 + 5);
      q_in     = 8'(i * 11 + 3);
      theta_in = 8'(i * 29);
    end
  endtask

  task automatic drain(input string tag);
    idle(6);
    chk(rd_idx == wr_idx, {tag, " all results delivered"}, rd_idx, wr_idx);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(g_out == '0, "R1 g after reset", int'(g_out), 0);
    chk(h_out == '0, "R1 h after reset", int'(h_out), 0);
  endtask

  task automatic t_quarter();
    push(32, 0, 64, 0, "R2 quarter-turn cosine");
    push(32, 0, 0, 2, "R2 angle zero");
    push(32, 0, 128, 2, "R2 half turn");
    drain("R2");
  endtask

  task automatic t_sweep_unit();
    for (int a = 0; a < 256; a++) push(32, 0, a, 2, "R4 sweep d=1");
    drain("R4");
  endtask

  task automatic t_sweep_mixed();
    for (int a = 0; a < 256; a++) push(20, -45, a, 2, "R3 sweep signed d,q");
    drain("R3");
  endtask

  task automatic t_rounding();
    push(1, 0, 0, 2, "R5 one input LSB");
    push(-1, 1, 37, 2, "R5 small negative");
    push(7, -3, 201, 2, "R5 mixed small");
    drain("R5");
  endtask

  task automatic t_saturate();
    push(127, 127, 0, 0, "R6 h clamps high");
    push(-128, -128, 0, 0, "R6 h clamps low");
    push(127, -128, 0, 0, "R6 g clamps high");
    push(-128, 127, 0, 0, "R6 g clamps low");
    push(127, 0, 192, 0, "R6 h low, g in range");
    drain("R6");
  endtask

  task automatic t_gaps();
    push(40, 10, 17, 2, "R7 gap pattern");
    idle(1);
    push(-30, 25, 90, 2, "R7 gap pattern");
    idle(2);
    push(50, -60, 250, 2, "R7 gap pattern");
    push(-70, -5, 3, 2, "R7 gap pattern");
    drain("R7");
  endtask

  task automatic t_hold();
    int lg, lh;
    push(60, -20, 45, 2, "R8 burst");
    push(-33, 44, 150, 2, "R8 burst");
    drain("R8");
    lg = int'(g_out);
    lh = int'(h_out);
    for (int i = 0; i < 4; i++) begin
      idle(1);
      chk(out_valid == 1'b0, "R8 idle out_valid", int'(out_valid), 0);
      chk(int'(g_out) == lg, "R8 g held", int'(g_out), lg);
      chk(int'(h_out) == lh, "R8 h held", int'(h_out), lh);
    end
  endtask

  task automatic t_zero();
    push(0, 0, 77, 0, "R9 zero vector");
    push(0, 0, 200, 0, "R9 zero vector");
    push(-90, 0, 0, 0, "R9 angle 0 q 0");
    push(100, 0, 0, 2, "R9 angle 0 q 0 g");
    drain("R9");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) hist[i] = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    mon_on = 1'b1;
    t_quarter();
    t_sweep_unit();
    t_sweep_mixed();
    t_rounding();
    t_saturate();
    t_gaps();
    t_hold();
    t_zero();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == LIMIT && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule